// File: doc/BRIEF.md
# Virtual Command Queue Configuration Registers

This block is the configuration page of a virtual command-queue controller. It sits on a plain 32-bit register bus with an address, a write strobe with its data, and a read strobe with its data. It holds the global controller settings and a read-only capability word. It also holds the per-interface interrupt masks, a small table that binds physical queues to logical queues and owning interfaces, and the register set of virtual interface 0. That set covers the interface setup, its status, and sixteen pairs of stream-ID match and replace words.

Software configures the controller by writing this block and learns whether an enable took hold by reading the matching status bit. Two writes have side effects: a global or interface enable is copied into a status bit that the bus cannot write. The hypervisor-ownership bit of the interface setup word is always stored as zero. The error maps are read-only and read as zero, because no error source is attached. Every offset that is not mapped reads as zero, and writes to it are dropped.

Top module: `vcq_cfg_regs`

## Requirements
- R1: After reset, every stored register reads as zero. PARAM is the exception and always shows its constant value.
- R2: A write to CONFIG (0x0) stores all 32 bits and copies data bit 0 into bit 0 of STATUS (0x8). STATUS reads zero in bits 31:1. A write to STATUS itself has no effect.
- R3: PARAM (0x4) reads 0x4011 with default parameters. The layout is version 1 in bits 3:0, log2 queue count 1 in bits 7:4, log2 interface count 0 in bits 11:8 and log2 stream IDs per interface 4 in bits 15:12. Writes to PARAM are ignored.
- R4: The interface interrupt masks at 0x1C and 0x20 are read/write. The interface error maps at 0x14 and 0x18 and the queue error maps at 0x24, 0x28, 0x2C and 0x30 read zero, and writes to them are ignored.
- R5: The queue allocation entries at 0x200 and 0x204 are read/write, each holding 32 bits independently.
- R6: A write to interface setup (0x1000) stores the data with bit 17 (hypervisor ownership) forced to 0.
- R7: A write to interface setup copies data bit 0 into bit 0 of interface status (0x1004). The other bits of that status read zero, and a write to 0x1004 has no effect.
- R8: Sixteen stream-ID match words at 0x1040 + 4*j and sixteen replace words at 0x1080 + 4*j (j = 0..15) are read/write and independent of each other.
- R9: The four logical-queue error maps at 0x10C0 to 0x10CC read zero, and writes to them are ignored.
- R10: An address with bits 1:0 nonzero, an address at or above 0x10000, or any unmapped offset reads zero. A write to such an address changes no register; in particular, 0x10000 does not alias 0x0.
- R11: rd_data_o is the combinational value of the addressed register while rd_en_i is high, and zero while it is low. A write takes effect at the clock edge, so a read in the same cycle returns the old value and a read in the next cycle returns the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (20) | Byte address of the access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, zero when rd_en_i is low |

## Verification
The assertions check several relations on every clock. A global or interface setup write must appear in the stored word and its status bit on the next edge, and the ownership bit must be cleared. The global status must hold whenever no setup write occurs. The read port must be zero while idle or misaligned, and the version field must read correctly. Only the bench scenarios can show the rest, against a behavioural address-keyed model: that stray, out-of-page and read-only writes leave every register untouched, that the 32 stream-ID words do not alias each other, and that a read in the write cycle still returns the old value.

// File: rtl/vcq_cfg_pkg.sv
package vcq_cfg_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned NIMASK  = 2;
  localparam logic [3:0]  VERSION = 4'd1;

  localparam logic [15:0] OFF_CFG    = 16'h0000;
  localparam logic [15:0] OFF_PARAM  = 16'h0004;
  localparam logic [15:0] OFF_STAT   = 16'h0008;
  localparam logic [15:0] OFF_IMASK  = 16'h001C;
  localparam logic [15:0] OFF_ALLOC  = 16'h0200;
  localparam logic [15:0] OFF_ICFG   = 16'h1000;
  localparam logic [15:0] OFF_ISTAT  = 16'h1004;
  localparam logic [15:0] OFF_SMATCH = 16'h1040;
  localparam logic [15:0] OFF_SREPL  = 16'h1080;

  localparam int unsigned HYP_BIT = 17;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CFG, SEL_PARAM, SEL_STAT, SEL_IMASK, SEL_ALLOC,
    SEL_ICFG, SEL_ISTAT, SEL_SMATCH, SEL_SREPL
  } sel_e;

  typedef struct packed {
    sel_e             sel;
    logic [IDX_W-1:0] idx;
  } dec_t;

  function automatic logic [DATA_W-1:0] param_word(input int q_log2, input int i_log2,
                                                   input int s_log2);
    return {16'h0, 4'(s_log2), 4'(i_log2), 4'(q_log2), VERSION};
  endfunction
endpackage

// File: rtl/vcq_addr_dec.sv
module vcq_addr_dec
  import vcq_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned NQ     = 2,
  parameter int unsigned NSID   = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  logic [15:0] off;
  logic        in_page;

  assign off = addr_i[15:0];

  generate
    if (ADDR_W > 16) begin : g_hi
      assign in_page = (addr_i[ADDR_W-1:16] == '0) && (addr_i[1:0] == 2'b00);
    end else begin : g_nohi
      assign in_page = (addr_i[1:0] == 2'b00);
    end
  endgenerate

  function automatic logic hit(input logic [15:0] o, input logic [15:0] base, input int n);
    return (32'(o) >= 32'(base)) && (32'(o) < 32'(base) + 32'(4 * n));
  endfunction

  function automatic logic [IDX_W-1:0] rel(input logic [15:0] o, input logic [15:0] base);
    logic [15:0] d;
    d = o - base;
    return IDX_W'(d >> 2);
  endfunction

  always_comb begin
    dec_o.sel = SEL_NONE;
    dec_o.idx = '0;
    if (in_page) begin
      if (off == OFF_CFG)              dec_o.sel = SEL_CFG;
      else if (off == OFF_PARAM)       dec_o.sel = SEL_PARAM;
      else if (off == OFF_STAT)        dec_o.sel = SEL_STAT;
      else if (hit(off, OFF_IMASK, NIMASK)) begin
        dec_o.sel = SEL_IMASK;
        dec_o.idx = rel(off, OFF_IMASK);
      end else if (hit(off, OFF_ALLOC, NQ)) begin
        dec_o.sel = SEL_ALLOC;
        dec_o.idx = rel(off, OFF_ALLOC);
      end else if (off == OFF_ICFG)    dec_o.sel = SEL_ICFG;
      else if (off == OFF_ISTAT)       dec_o.sel = SEL_ISTAT;
      else if (hit(off, OFF_SMATCH, NSID)) begin
        dec_o.sel = SEL_SMATCH;
        dec_o.idx = rel(off, OFF_SMATCH);
      end else if (hit(off, OFF_SREPL, NSID)) begin
        dec_o.sel = SEL_SREPL;
        dec_o.idx = rel(off, OFF_SREPL);
      end
      // error maps and everything else fall through to SEL_NONE: read zero
    end
  end
endmodule

// File: rtl/vcq_glb_regs.sv
module vcq_glb_regs
  import vcq_cfg_pkg::*;
#(
  parameter int unsigned NQ = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  sel_e                          sel_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             cfg_o,
  output logic                          stat_o,
  output logic [NIMASK-1:0][DATA_W-1:0] imask_o,
  output logic [NQ-1:0][DATA_W-1:0]     alloc_o
);
  logic cfg_we;
  assign cfg_we = we_i && (sel_i == SEL_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= '0;
      stat_o <= 1'b0;
    end else if (cfg_we) begin
      cfg_o  <= wdata_i;
      stat_o <= wdata_i[0];
    end
  end

  for (genvar i = 0; i < NIMASK; i++) begin : g_imask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) imask_o[i] <= '0;
      else if (we_i && sel_i == SEL_IMASK && idx_i == IDX_W'(i)) imask_o[i] <= wdata_i;
    end
  end

  for (genvar i = 0; i < NQ; i++) begin : g_alloc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) alloc_o[i] <= '0;
      else if (we_i && sel_i == SEL_ALLOC && idx_i == IDX_W'(i)) alloc_o[i] <= wdata_i;
    end
  end

  assert_cfg_mirror_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we |=> (cfg_o == $past(wdata_i)) && (stat_o == $past(wdata_i[0])));

  assert_stat_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we |=> $stable(stat_o));
endmodule

// File: rtl/vcq_intf_regs.sv
module vcq_intf_regs
  import vcq_cfg_pkg::*;
#(
  parameter int unsigned NSID = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  sel_e                        sel_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           cfg_o,
  output logic                        enok_o,
  output logic [NSID-1:0][DATA_W-1:0] match_o,
  output logic [NSID-1:0][DATA_W-1:0] repl_o
);
  localparam logic [DATA_W-1:0] HYP_MASK = DATA_W'(1) << HYP_BIT;

  logic icfg_we;
  assign icfg_we = we_i && (sel_i == SEL_ICFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= '0;
      enok_o <= 1'b0;
    end else if (icfg_we) begin
      cfg_o  <= wdata_i & ~HYP_MASK;
      enok_o <= wdata_i[0];
    end
  end

  for (genvar j = 0; j < NSID; j++) begin : g_sid
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        match_o[j] <= '0;
        repl_o[j]  <= '0;
      end else if (we_i && idx_i == IDX_W'(j)) begin
        if (sel_i == SEL_SMATCH) match_o[j] <= wdata_i;
        if (sel_i == SEL_SREPL)  repl_o[j]  <= wdata_i;
      end
    end
  end

  assert_hyp_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icfg_we |=> (cfg_o[HYP_BIT] == 1'b0) &&
                (cfg_o[HYP_BIT-1:0] == $past(wdata_i[HYP_BIT-1:0])));

  assert_enok_mirror_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icfg_we |=> enok_o == $past(wdata_i[0]));
endmodule

// File: rtl/vcq_cfg_regs.sv
module vcq_cfg_regs
  import vcq_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned QUEUE_LOG2 = 1,
  parameter int unsigned INTF_LOG2  = 0,
  parameter int unsigned SID_LOG2   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  output logic [31:0]       rd_data_o
);
  localparam int unsigned NQ   = 2 ** QUEUE_LOG2;
  localparam int unsigned NSID = 2 ** SID_LOG2;
  localparam int unsigned QW   = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int unsigned SW   = (NSID > 1) ? $clog2(NSID) : 1;
  localparam logic [DATA_W-1:0] PARAM_VAL = param_word(QUEUE_LOG2, INTF_LOG2, SID_LOG2);

  dec_t                          dec;
  logic [DATA_W-1:0]             cfg, icfg;
  logic                          stat, enok;
  logic [NIMASK-1:0][DATA_W-1:0] imask;
  logic [NQ-1:0][DATA_W-1:0]     alloc;
  logic [NSID-1:0][DATA_W-1:0]   match, repl;
  logic [DATA_W-1:0]             rd_val;

  vcq_addr_dec #(.ADDR_W(ADDR_W), .NQ(NQ), .NSID(NSID)) i_dec (
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  vcq_glb_regs #(.NQ(NQ)) i_glb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .sel_i   (dec.sel),
    .idx_i   (dec.idx),
    .wdata_i (wr_data_i),
    .cfg_o   (cfg),
    .stat_o  (stat),
    .imask_o (imask),
    .alloc_o (alloc)
  );

  vcq_intf_regs #(.NSID(NSID)) i_intf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .sel_i   (dec.sel),
    .idx_i   (dec.idx),
    .wdata_i (wr_data_i),
    .cfg_o   (icfg),
    .enok_o  (enok),
    .match_o (match),
    .repl_o  (repl)
  );

  always_comb begin
    case (dec.sel)
      SEL_CFG:    rd_val = cfg;
      SEL_PARAM:  rd_val = PARAM_VAL;
      SEL_STAT:   rd_val = {31'b0, stat};
      SEL_IMASK:  rd_val = imask[dec.idx[0]];
      SEL_ALLOC:  rd_val = alloc[dec.idx[QW-1:0]];
      SEL_ICFG:   rd_val = icfg;
      SEL_ISTAT:  rd_val = {31'b0, enok};
      SEL_SMATCH: rd_val = match[dec.idx[SW-1:0]];
      SEL_SREPL:  rd_val = repl[dec.idx[SW-1:0]];
      default:    rd_val = '0;
    endcase
  end

  assign rd_data_o = rd_en_i ? rd_val : '0;

  assert_idle_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rd_data_o == '0);

  assert_misalign_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[1:0] != 2'b00) |-> rd_data_o == '0);

  assert_param_ver_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(OFF_PARAM)) |-> rd_data_o[3:0] == 4'd1);
endmodule

// File: tb/test_vcq_cfg_regs.sv
module test_vcq_cfg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        re = 1'b0;
  logic [31:0] rdata;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic [31:0] mdl [int];

  always #2.5 clk = ~clk;

  vcq_cfg_regs i_vcq_cfg_regs (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .wr_en_i   (we),
    .wr_data_i (wdata),
    .rd_en_i   (re),
    .rd_data_o (rdata)
  );

  function automatic bit in_rw(int a);
    if (a == 'h0 || a == 'h1C || a == 'h20 || a == 'h200 || a == 'h204 || a == 'h1000) return 1;
    if (a >= 'h1040 && a < 'h10C0) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] mdl_rd(int a);
    if (a[1:0] != 0 || a >= 'h10000) return 0;
    if (a == 'h4) return 32'h4011;
    if (mdl.exists(a)) return mdl[a];
    return 0;
  endfunction

  task automatic mdl_wr(int a, logic [31:0] d);
    if (a[1:0] != 0 || a >= 'h10000 || !in_rw(a)) return;
    if (a == 'h0) begin
      mdl[a] = d;
      mdl['h8] = {31'b0, d[0]};
    end else if (a == 'h1000) begin
      mdl[a] = d & ~(32'h1 << 17);
      mdl['h1004] = {31'b0, d[0]};
    end else mdl[a] = d;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit w, int a, logic [31:0] d, bit r, string tag);
    @(negedge clk);
    we = w; addr = 20'(a); wdata = d; re = r;
    #1;
    check(tag, rdata, r ? mdl_rd(a) : 32'h0);
    @(posedge clk);
    if (w) mdl_wr(a, d);
  endtask

  task automatic wr(int a, logic [31:0] d, string tag);
    cyc(1'b1, a, d, 1'b0, tag);
  endtask

  task automatic rd(int a, string tag);
    cyc(1'b0, a, 32'h0, 1'b1, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int pool [20];
    pool = '{'h0, 'h4, 'h8, 'h14, 'h1C, 'h20, 'h24, 'h200, 'h204, 'h208,
             'h1000, 'h1004, 'h1044, 'h107C, 'h1080, 'h10BC, 'h10C0, 'h10000, 'h11000, 'h1002};
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd('h0, "R1"); rd('h8, "R1"); rd('h1C, "R1"); rd('h200, "R1"); rd('h204, "R1");
    rd('h1000, "R1"); rd('h1004, "R1"); rd('h1040, "R1"); rd('h10BC, "R1");

    // R3: constant capability word, write ignored
    rd('h4, "R3");
    wr('h4, 32'hFFFF_FFFF, "R3");
    rd('h4, "R3");

    // R2: global enable mirrored into status; status write ignored
    wr('h0, 32'h001F_FFFF, "R2");
    rd('h0, "R2"); rd('h8, "R2");
    wr('h8, 32'h0, "R2");
    rd('h8, "R2");
    wr('h0, 32'h0012_3456, "R2");
    rd('h8, "R2"); rd('h0, "R2");

    // R4: masks rw, error maps read zero
    wr('h1C, 32'hA5A5_0001, "R4"); wr('h20, 32'h5A5A_0002, "R4");
    rd('h1C, "R4"); rd('h20, "R4");
    wr('h14, 32'hFFFF_FFFF, "R4"); wr('h18, 32'hFFFF_FFFF, "R4"); wr('h30, 32'hFFFF_FFFF, "R4");
    rd('h14, "R4"); rd('h18, "R4"); rd('h24, "R4"); rd('h30, "R4");

    // R5: allocation entries
    wr('h200, 32'h001F_80FF, "R5"); wr('h204, 32'hDEAD_BEEF, "R5");
    rd('h200, "R5"); rd('h204, "R5");

    // R6 / R7: interface setup and status
    wr('h1000, 32'hFFFF_FFFF, "R6");
    rd('h1000, "R6"); rd('h1004, "R7");
    wr('h1004, 32'h0, "R7");
    rd('h1004, "R7");
    wr('h1000, 32'h0002_0002, "R6");
    rd('h1000, "R6"); rd('h1004, "R7");

    // R8: stream-ID words, independent
    for (int j = 0; j < 16; j++) wr('h1040 + 4 * j, 32'h1000 + j, "R8");
    for (int j = 0; j < 16; j++) wr('h1080 + 4 * j, 32'h2_0000 + j * 3, "R8");
    for (int j = 0; j < 16; j++) begin rd('h1040 + 4 * j, "R8"); rd('h1080 + 4 * j, "R8"); end

    // R9: logical-queue error maps
    for (int j = 0; j < 4; j++) wr('h10C0 + 4 * j, 32'hFFFF_FFFF, "R9");
    for (int j = 0; j < 4; j++) rd('h10C0 + 4 * j, "R9");

    // R10: out of page, misaligned, unmapped
    wr('h10000, 32'hCAFE_0001, "R10"); rd('h0, "R10"); rd('h10000, "R10");
    wr('h1001, 32'hCAFE_0002, "R10"); rd('h1000, "R10"); rd('h1001, "R10");
    wr('h208, 32'hCAFE_0003, "R10"); rd('h208, "R10"); rd('h204, "R10");
    wr('h300, 32'hCAFE_0004, "R10"); rd('h300, "R10");

    // R11: idle read is zero, old value in write cycle, new value next
    cyc(1'b0, 'h204, 32'h0, 1'b0, "R11");
    cyc(1'b1, 'h204, 32'h1234_5678, 1'b1, "R11");
    rd('h204, "R11");

    // R11: mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      int a;
      a = pool[$urandom_range(19, 0)];
      cyc(1'($urandom_range(1, 0)), a, $urandom, 1'($urandom_range(3, 0) != 0), "R11");
    end

    @(negedge clk);
    we = 1'b0; re = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule